// File: doc/BRIEF.md
# Super I/O Configuration Register Space

This block decodes a two-address configuration window on a byte-wide host I/O bus. The host writes a register number to the index address. Each later access to the data address, read or write, reaches the register that number selects. A strap input chooses where the window sits: either 0x2E/0x2F or 0x4E/0x4F. The index is held until the host writes it again, so the host can read or write the same register several times in a row.

Some registers are global: a fixed chip identity, a chip enable bit and a logical-device selector. Three units can be selected (codes 0x07, 0x0D and 0x0E). Each unit has its own bank with an activate byte and a 16-bit runtime base address. Unit 0x07 is the pin-control unit. It also gives indirect access to a configuration byte and an event byte for each of its 32 pins, through an encoded pin selector.

The block drives these outputs to the runtime pin logic: the pin unit's base address, its enable, and the flattened configuration and event bytes of all pins.

Top module: `sio_cfg_space`

## Requirements
- R1: After reset the following values hold: device select is 0xFF, chip enable bit is 1, every activate byte is 0x00, every base address is 0x0000, every pin byte is 0x00, index and pin selector are 0x00.
- R2: The index address is 0x2E when `strap_alt` is 0 and 0x4E when it is 1; the data address is index address + 1. Writes to any other address are ignored. A read of the index address returns the current index. `io_rdata` is 0x00 whenever `io_rd` is low.
- R3: Register 0x20 always reads 0xE9; writes to it are ignored.
- R4: Bit 0 of register 0x21 is the chip enable. It reads back as {7'b0, enable}; the other bits are not stored.
- R5: Register 0x07 holds the selected device code and reads back the full byte.
- R6: Registers 0x30 (activate), 0x60 (base high byte) and 0x61 (base low byte) are banked. Devices 0x07, 0x0D and 0x0E each own a separate copy, and only the selected device's copy is read or written.
- R7: A data read of a register with no storage, or of a banked register while no known device is selected, returns 0xFF. Writes to it change nothing.
- R8: `gpio_base` equals the base address of device 0x07. `gpio_en` is high when the chip enable is 1 and device 0x07's activate byte is nonzero.
- R9: Register 0xF0 is the pin selector. Bits 5:4 give the port and bits 2:0 give the bit; the pin number is port*8+bit. Only these bits are stored; bits 7, 6 and 3 read 0.
- R10: Register 0xF1 reads and writes the selected pin's configuration byte, and 0xF2 does the same for its event byte. A write changes only the selected pin. Pin p occupies bits [8p+7:8p] of `pin_cfg_flat` and `pin_evt_flat`.
- R11: The index keeps its value across any number of data accesses.
- R12: Registers 0xF0 to 0xF2 exist only while device 0x07 is selected. Otherwise they read 0xFF and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Selects the 0x4E window instead of 0x2E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe; read data is combinational |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data |
| gpio_base | output | 16 | Runtime base address of the pin unit |
| gpio_en | output | 1 | Pin unit enabled |
| pin_cfg_flat | output | 256 | Configuration byte of each pin |
| pin_evt_flat | output | 256 | Event byte of each pin |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle. They also assume that `strap_alt` changes only while the bus is idle, so the decoded window is fixed during any access. The stimulus follows both rules. Each task drives a single strobe for one cycle and then drops it before the next access starts. The strap is changed only between accesses, at a falling edge.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;
  localparam int          BYTE_W      = 8;
  localparam logic [7:0]  RI_DEVSEL   = 8'h07;
  localparam logic [7:0]  RI_IDENT    = 8'h20;
  localparam logic [7:0]  RI_CHIPEN   = 8'h21;
  localparam logic [7:0]  RI_ACTIVE   = 8'h30;
  localparam logic [7:0]  RI_BASE_HI  = 8'h60;
  localparam logic [7:0]  RI_BASE_LO  = 8'h61;
  localparam logic [7:0]  RI_PINSEL   = 8'hF0;
  localparam logic [7:0]  RI_PINCFG   = 8'hF1;
  localparam logic [7:0]  RI_PINEVT   = 8'hF2;
  localparam logic [7:0]  IDENT_VAL   = 8'hE9;
  localparam logic [7:0]  DEV_NONE    = 8'hFF;
  localparam logic [7:0]  DEV_PINS    = 8'h07;
  localparam logic [7:0]  RD_EMPTY    = 8'hFF;
  localparam int          N_UNITS     = 3;
  // unit codes, slot g at bits [8g+7:8g]
  localparam logic [N_UNITS*8-1:0] UNIT_CODES = {8'h0E, 8'h0D, 8'h07};
endpackage

// File: rtl/sio_unit_bank.sv
`timescale 1ns/1ps
module sio_unit_bank
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] UNIT_CODE = 8'h07,
  parameter int         AW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    dev_sel,
  input  logic [7:0]    idx,
  input  logic [7:0]    wdata,
  input  logic          data_we,
  output logic [7:0]    act,
  output logic [AW-1:0] base,
  output logic          rd_hit,
  output logic [7:0]    rd_val
);
  localparam int HI_W = AW - BYTE_W;

  logic          selected;
  logic          bank_we;
  logic [7:0]    act_d;
  logic [AW-1:0] base_d;

  assign selected = (dev_sel == UNIT_CODE);
  assign bank_we  = selected && data_we;

  always_comb begin
    act_d  = act;
    base_d = base;
    if (bank_we) begin
      case (idx)
        RI_ACTIVE:  act_d            = wdata;
        RI_BASE_HI: base_d[AW-1:8]   = wdata[HI_W-1:0];
        RI_BASE_LO: base_d[7:0]      = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= '0;
      base <= '0;
    end else if (bank_we) begin
      act  <= act_d;
      base <= base_d;
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_val = RD_EMPTY;
    if (selected) begin
      case (idx)
        RI_ACTIVE:  begin rd_hit = 1'b1; rd_val = act; end
        RI_BASE_HI: begin rd_hit = 1'b1; rd_val = 8'(base[AW-1:8]); end
        RI_BASE_LO: begin rd_hit = 1'b1; rd_val = base[7:0]; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sio_pin_store.sv
`timescale 1ns/1ps
module sio_pin_store #(
  parameter int  N_PINS = 32,
  localparam int PIN_W  = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pin_idx,
  input  logic              cfg_we,
  input  logic              evt_we,
  input  logic [7:0]        wdata,
  output logic [7:0]        cfg_rd,
  output logic [7:0]        evt_rd,
  output logic [N_PINS*8-1:0] cfg_flat,
  output logic [N_PINS*8-1:0] evt_flat
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic       hit;
    logic [7:0] cfg_q;
    logic [7:0] evt_q;
    assign hit = (pin_idx == PIN_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
        evt_q <= '0;
      end else begin
        if (cfg_we && hit) cfg_q <= wdata;
        if (evt_we && hit) evt_q <= wdata;
      end
    end
    assign cfg_flat[p*8 +: 8] = cfg_q;
    assign evt_flat[p*8 +: 8] = evt_q;
  end

  assign cfg_rd = cfg_flat[int'(pin_idx)*8 +: 8];
  assign evt_rd = evt_flat[int'(pin_idx)*8 +: 8];
endmodule

// File: rtl/sio_cfg_space.sv
`timescale 1ns/1ps
module sio_cfg_space
  import sio_cfg_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            N_PINS      = 32,
  parameter logic [AW-1:0] PORT_BASE_A = 16'h002E,
  parameter logic [AW-1:0] PORT_BASE_B = 16'h004E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strap_alt,
  input  logic [AW-1:0]       io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  output logic [AW-1:0]       gpio_base,
  output logic                gpio_en,
  output logic [N_PINS*8-1:0] pin_cfg_flat,
  output logic [N_PINS*8-1:0] pin_evt_flat
);
  localparam int         PIN_W    = $clog2(N_PINS);
  localparam int         PORT_W   = PIN_W - 3;
  localparam logic [7:0] SEL_MASK = 8'((((1 << PORT_W) - 1) << 4) | 7);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [AW-1:0] port_base;
  logic          idx_sel, dat_sel, idx_we, data_we;
  assign port_base = strap_alt ? PORT_BASE_B : PORT_BASE_A;
  assign idx_sel   = (io_addr == port_base);
  assign dat_sel   = (io_addr == port_base + AW'(1));
  assign idx_we    = io_wr && idx_sel;
  assign data_we   = io_wr && dat_sel;

  logic [7:0] idx_q, idx_d;
  logic [7:0] dev_sel_q, dev_sel_d;
  logic       chip_en_q, chip_en_d;
  logic [7:0] pin_sel_q, pin_sel_d;
  logic       pins_sel;

  assign pins_sel = (dev_sel_q == DEV_PINS);

  always_comb begin
    idx_d     = idx_q;
    dev_sel_d = dev_sel_q;
    chip_en_d = chip_en_q;
    pin_sel_d = pin_sel_q;
    if (idx_we) idx_d = io_wdata;
    if (data_we) begin
      case (idx_q)
        RI_DEVSEL: dev_sel_d = io_wdata;
        RI_CHIPEN: chip_en_d = io_wdata[0];
        RI_PINSEL: if (pins_sel) pin_sel_d = io_wdata & SEL_MASK;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q     <= '0;
      dev_sel_q <= DEV_NONE;
      chip_en_q <= 1'b1;
      pin_sel_q <= '0;
    end else begin
      if (idx_we)  idx_q <= idx_d;
      if (data_we) begin
        dev_sel_q <= dev_sel_d;
        chip_en_q <= chip_en_d;
        pin_sel_q <= pin_sel_d;
      end
    end
  end

  // banked unit registers
  logic [7:0]    bank_act [N_UNITS];
  logic [AW-1:0] bank_base[N_UNITS];
  logic [7:0]    bank_val [N_UNITS];
  logic          bank_hit [N_UNITS];

  for (genvar g = 0; g < N_UNITS; g++) begin : g_bank
    sio_unit_bank #(
      .UNIT_CODE (UNIT_CODES[g*8 +: 8]),
      .AW        (AW)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .dev_sel (dev_sel_q),
      .idx     (idx_q),
      .wdata   (io_wdata),
      .data_we (data_we),
      .act     (bank_act[g]),
      .base    (bank_base[g]),
      .rd_hit  (bank_hit[g]),
      .rd_val  (bank_val[g])
    );
  end

  // per-pin storage behind the selector
  logic [PIN_W-1:0] pin_idx;
  logic             cfg_we, evt_we;
  logic [7:0]       cfg_rd, evt_rd;

  assign pin_idx = {pin_sel_q[4 +: PORT_W], pin_sel_q[2:0]};
  assign cfg_we  = data_we && pins_sel && (idx_q == RI_PINCFG);
  assign evt_we  = data_we && pins_sel && (idx_q == RI_PINEVT);

  sio_pin_store #(.N_PINS(N_PINS)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pin_idx  (pin_idx),
    .cfg_we   (cfg_we),
    .evt_we   (evt_we),
    .wdata    (io_wdata),
    .cfg_rd   (cfg_rd),
    .evt_rd   (evt_rd),
    .cfg_flat (pin_cfg_flat),
    .evt_flat (pin_evt_flat)
  );

  // runtime outputs of the pin unit
  logic pins_active;
  always_comb begin
    gpio_base   = '0;
    pins_active = 1'b0;
    for (int g = 0; g < N_UNITS; g++) begin
      if (UNIT_CODES[g*8 +: 8] == DEV_PINS) begin
        gpio_base   = gpio_base | bank_base[g];
        pins_active = pins_active | (|bank_act[g]);
      end
    end
  end
  assign gpio_en = chip_en_q && pins_active;

  // read path
  logic [7:0] data_rd;
  always_comb begin
    data_rd = RD_EMPTY;
    case (idx_q)
      RI_IDENT:  data_rd = IDENT_VAL;
      RI_DEVSEL: data_rd = dev_sel_q;
      RI_CHIPEN: data_rd = {7'b0, chip_en_q};
      RI_PINSEL: data_rd = pins_sel ? pin_sel_q : RD_EMPTY;
      RI_PINCFG: data_rd = pins_sel ? cfg_rd    : RD_EMPTY;
      RI_PINEVT: data_rd = pins_sel ? evt_rd    : RD_EMPTY;
      default: begin
        for (int g = 0; g < N_UNITS; g++)
          if (bank_hit[g]) data_rd = bank_val[g];
      end
    endcase
  end

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (idx_sel)      io_rdata = idx_q;
      else if (dat_sel) io_rdata = data_rd;
    end
  end
endmodule

// File: rtl/sio_cfg_space_chk.sv
`timescale 1ns/1ps
module sio_cfg_space_chk #(
  parameter int            AW          = 16,
  parameter int            N_PINS      = 32,
  parameter logic [AW-1:0] PORT_BASE_A = 16'h002E,
  parameter logic [AW-1:0] PORT_BASE_B = 16'h004E
) (
  input logic                clk,
  input logic                rst_n,
  input logic                strap_alt,
  input logic [AW-1:0]       io_addr,
  input logic                io_wr,
  input logic                io_rd,
  input logic [7:0]          io_rdata,
  input logic [AW-1:0]       gpio_base,
  input logic [N_PINS*8-1:0] pin_cfg_flat,
  input logic [7:0]          idx_q,
  input logic [7:0]          dev_sel_q
);
  logic [AW-1:0] win;
  logic          at_idx, at_dat, known_dev, banked_idx;
  assign win        = strap_alt ? PORT_BASE_B : PORT_BASE_A;
  assign at_idx     = (io_addr == win);
  assign at_dat     = (io_addr == win + AW'(1));
  assign known_dev  = (dev_sel_q == 8'h07) || (dev_sel_q == 8'h0D) || (dev_sel_q == 8'h0E);
  assign banked_idx = (idx_q == 8'h30) || (idx_q == 8'h60) || (idx_q == 8'h61);

  AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && idx_q == 8'h20) |-> (io_rdata == 8'hE9)); // R3

  AST_NO_BANK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_dat && banked_idx && !known_dev) |-> (io_rdata == 8'hFF)); // R7

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00)); // R2

  AST_INDEX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_idx) |=> $stable(idx_q)); // R11

  AST_BASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_dat) |=> $stable(gpio_base)); // R8

  AST_PINCFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && at_dat) |=> $stable(pin_cfg_flat)); // R10
endmodule

bind sio_cfg_space sio_cfg_space_chk #(
  .AW(AW), .N_PINS(N_PINS), .PORT_BASE_A(PORT_BASE_A), .PORT_BASE_B(PORT_BASE_B)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .strap_alt    (strap_alt),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_rdata     (io_rdata),
  .gpio_base    (gpio_base),
  .pin_cfg_flat (pin_cfg_flat),
  .idx_q        (idx_q),
  .dev_sel_q    (dev_sel_q)
);

// File: tb/sio_cfg_space_test.sv
`timescale 1ns/1ps
module sio_cfg_space_test;
  localparam int          NPIN = 32;
  localparam logic [15:0] IA   = 16'h002E;
  localparam logic [15:0] DA   = 16'h002F;
  localparam logic [15:0] IB   = 16'h004E;
  localparam logic [15:0] DB   = 16'h004F;
  localparam logic [1:0]  WI = 2'd0, WD = 2'd1, RD = 2'd2;
  localparam int NV = 64;
  // {op, data, expected, requirement number}
  localparam logic [21:0] VEC [NV] = '{
    {WI, 8'h20, 8'h00, 4'd0}, {RD, 8'h00, 8'hE9, 4'd3},           // R3
    {WD, 8'h55, 8'h00, 4'd0}, {RD, 8'h00, 8'hE9, 4'd3},           // R3 write ignored
    {WI, 8'h07, 8'h00, 4'd0}, {RD, 8'h00, 8'hFF, 4'd1},           // R1
    {WI, 8'h30, 8'h00, 4'd0}, {RD, 8'h00, 8'hFF, 4'd7},           // R7
    {WI, 8'h07, 8'h00, 4'd0}, {WD, 8'h07, 8'h00, 4'd0},
    {RD, 8'h00, 8'h07, 4'd5},                                     // R5
    {WI, 8'h30, 8'h00, 4'd0}, {RD, 8'h00, 8'h00, 4'd1},           // R1
    {WD, 8'h01, 8'h00, 4'd0}, {RD, 8'h00, 8'h01, 4'd6},           // R6
    {WI, 8'h60, 8'h00, 4'd0}, {WD, 8'h12, 8'h00, 4'd0},
    {WI, 8'h61, 8'h00, 4'd0}, {WD, 8'h34, 8'h00, 4'd0},
    {RD, 8'h00, 8'h34, 4'd11}, {RD, 8'h00, 8'h34, 4'd11},         // R11
    {WI, 8'h07, 8'h00, 4'd0}, {WD, 8'h0D, 8'h00, 4'd0},
    {WI, 8'h30, 8'h00, 4'd0}, {RD, 8'h00, 8'h00, 4'd6},           // R6
    {WD, 8'h05, 8'h00, 4'd0}, {RD, 8'h00, 8'h05, 4'd6},
    {WI, 8'h60, 8'h00, 4'd0}, {WD, 8'hAB, 8'h00, 4'd0},
    {RD, 8'h00, 8'hAB, 4'd6},
    {WI, 8'hF1, 8'h00, 4'd0}, {RD, 8'h00, 8'hFF, 4'd12},          // R12
    {WD, 8'h33, 8'h00, 4'd0},
    {WI, 8'h07, 8'h00, 4'd0}, {WD, 8'h0E, 8'h00, 4'd0},
    {WI, 8'h61, 8'h00, 4'd0}, {RD, 8'h00, 8'h00, 4'd6},           // R6
    {WI, 8'h07, 8'h00, 4'd0}, {WD, 8'h07, 8'h00, 4'd0},
    {WI, 8'h50, 8'h00, 4'd0}, {RD, 8'h00, 8'hFF, 4'd7},           // R7
    {WD, 8'h77, 8'h00, 4'd0}, {RD, 8'h00, 8'hFF, 4'd7},
    {WI, 8'hF0, 8'h00, 4'd0}, {WD, 8'hFF, 8'h00, 4'd0},
    {RD, 8'h00, 8'h37, 4'd9},                                     // R9
    {WI, 8'hF1, 8'h00, 4'd0}, {RD, 8'h00, 8'h00, 4'd10},          // R10
    {WD, 8'hA5, 8'h00, 4'd0}, {RD, 8'h00, 8'hA5, 4'd10},
    {WI, 8'hF2, 8'h00, 4'd0}, {WD, 8'h5A, 8'h00, 4'd0},
    {RD, 8'h00, 8'h5A, 4'd10},
    {WI, 8'hF0, 8'h00, 4'd0}, {WD, 8'h0A, 8'h00, 4'd0},
    {RD, 8'h00, 8'h02, 4'd9},                                     // R9
    {WI, 8'hF1, 8'h00, 4'd0}, {RD, 8'h00, 8'h00, 4'd10},
    {WD, 8'h3C, 8'h00, 4'd0}, {RD, 8'h00, 8'h3C, 4'd10},
    {WI, 8'hF0, 8'h00, 4'd0}, {WD, 8'h37, 8'h00, 4'd0},
    {WI, 8'hF1, 8'h00, 4'd0}, {RD, 8'h00, 8'hA5, 4'd10}           // R10
  };

  logic               clk = 1'b0;
  logic               rst_n;
  logic               strap_alt;
  logic [15:0]        io_addr;
  logic               io_wr, io_rd;
  logic [7:0]         io_wdata;
  logic [7:0]         io_rdata;
  logic [15:0]        gpio_base;
  logic               gpio_en;
  logic [NPIN*8-1:0]  pin_cfg_flat, pin_evt_flat;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  sio_cfg_space uut (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .gpio_base(gpio_base), .gpio_en(gpio_en),
    .pin_cfg_flat(pin_cfg_flat), .pin_evt_flat(pin_evt_flat)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    rst_n = 1'b0; strap_alt = 1'b0; io_addr = '0;
    io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    do_reset();

    // reset state, R1
    chk(gpio_base == 16'h0, "R1 base", gpio_base, 0);
    chk(gpio_en == 1'b0, "R1 enable", gpio_en, 0);
    chk(pin_cfg_flat == '0 && pin_evt_flat == '0, "R1 pins", pin_cfg_flat[31:0], 0);
    bus_rd(IA, rv); chk(rv == 8'h00, "R1 index", rv, 8'h00);
    bus_wr(IA, 8'h21);
    bus_rd(DA, rv); chk(rv == 8'h01, "R1 chip enable", rv, 8'h01);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] dv, ev;
      logic [3:0] rq;
      {op, dv, ev, rq} = VEC[i];
      case (op)
        WI: bus_wr(IA, dv);
        WD: bus_wr(DA, dv);
        default: begin
          bus_rd(DA, rv);
          chk(rv == ev, $sformatf("R%0d vec %0d", rq, i), rv, ev);
        end
      endcase
    end

    // runtime outputs, R8 / R10 / R12
    chk(gpio_base == 16'h1234, "R8 base", gpio_base, 16'h1234);
    chk(gpio_en == 1'b1, "R8 enable", gpio_en, 1);
    chk(pin_cfg_flat[31*8 +: 8] == 8'hA5, "R10 cfg pin31", pin_cfg_flat[31*8 +: 8], 8'hA5);
    chk(pin_cfg_flat[2*8 +: 8] == 8'h3C, "R10 cfg pin2", pin_cfg_flat[2*8 +: 8], 8'h3C);
    chk(pin_evt_flat[31*8 +: 8] == 8'h5A, "R10 evt pin31", pin_evt_flat[31*8 +: 8], 8'h5A);
    chk(pin_evt_flat[2*8 +: 8] == 8'h00, "R10 evt pin2", pin_evt_flat[2*8 +: 8], 0);
    chk(pin_cfg_flat[7:0] == 8'h00, "R12 pin0 untouched", pin_cfg_flat[7:0], 0);

    // chip enable, R4
    bus_wr(IA, 8'h21); bus_wr(DA, 8'h00);
    bus_rd(DA, rv); chk(rv == 8'h00, "R4 clear", rv, 0);
    chk(gpio_en == 1'b0, "R4 enable gated", gpio_en, 0);
    bus_wr(DA, 8'hFE);
    bus_rd(DA, rv); chk(rv == 8'h00, "R4 upper bits", rv, 0);
    bus_wr(DA, 8'hFF);
    bus_rd(DA, rv); chk(rv == 8'h01, "R4 set", rv, 8'h01);
    chk(gpio_en == 1'b1, "R8 enable back", gpio_en, 1);

    // strap window, R2
    @(negedge clk); strap_alt = 1'b1;
    bus_wr(IA, 8'h20);
    bus_rd(DB, rv); chk(rv == 8'h01, "R2 old window ignored", rv, 8'h01);
    bus_wr(IB, 8'h20);
    bus_rd(DB, rv); chk(rv == 8'hE9, "R2 alt data", rv, 8'hE9);
    bus_rd(IB, rv); chk(rv == 8'h20, "R2 alt index", rv, 8'h20);
    bus_rd(DA, rv); chk(rv == 8'h00, "R2 off window", rv, 0);
    #1 chk(io_rdata == 8'h00, "R2 idle", io_rdata, 0);
    @(negedge clk); strap_alt = 1'b0;

    // reset again, R1
    do_reset();
    chk(gpio_base == 16'h0 && gpio_en == 1'b0, "R1 re-reset", gpio_base, 0);
    chk(pin_cfg_flat == '0, "R1 re-reset pins", pin_cfg_flat[31:0], 0);
    bus_wr(IA, 8'h07);
    bus_rd(DA, rv); chk(rv == 8'hFF, "R1 device none", rv, 8'hFF);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule